// File: doc/BRIEF.md
# Gated Result Port

This block holds processing results in a small first-in first-out queue and shows them one at a time on a 16-bit result bus. A data-valid output is high while a result is on the bus. The consumer moves to the next result by raising an advance input. The advance only counts while the select input is high.

Select also decides whether this instance drives the shared result bus. Two instances can therefore sit on one bus in a cascade, and only the selected one answers. With a single instance, select can simply be tied high. The bus drive is modelled as an output-enable flag, and the data output reads zero whenever that flag is low.

A processor-side read path can pop the same queue instead of the port. Results are meant to leave through one path only. If the port's advance and select stay low, every result waits in the queue until the processor takes it.

Top module: `rslt_port`

## Requirements
- R1: Results leave in the order they were written. While the port is enabled, `rp_data` shows the oldest queued result.
- R2: `rp_dv` is high exactly while at least one result is queued. It goes low in the cycle after the last result is popped.
- R3: A rising edge on `rp_adv` pops a result only if `rp_sel` is high in the same cycle. With `rp_sel` low the queue is left untouched.
- R4: `rp_adv` is edge-detected against its value in the previous cycle. Holding it high for many cycles pops exactly one result.
- R5: `rp_oe` is high only when `rp_sel` and `rp_dv` are both high. `rp_data` is all zeros whenever `rp_oe` is low.
- R6: The queue holds 8 results. A write that arrives while the queue is full, with no pop in the same cycle, is dropped and sets `ovf`. `ovf` then stays high until reset.
- R7: `rst_n` is active low and is sampled on the clock. It empties the queue, clears `ovf` and clears the advance edge history. Hold it for at least two cycles.
- R8: `cpu_data` always shows the oldest result, whatever `rp_sel` is, and is zero when the queue is empty. A high `cpu_rd` pops that result. With `rp_adv` and `rp_sel` low, results stay queued until `cpu_rd` takes them.
- R9: If `cpu_rd` and a valid port advance happen in the same cycle, exactly one result is popped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write a new result into the queue |
| wr_data | input | 16 | Result value to be written |
| rp_adv | input | 1 | Request the next result on the port (edge-detected) |
| rp_sel | input | 1 | Port select: enables the advance and the bus drive |
| cpu_rd | input | 1 | Processor-side pop of the oldest result |
| rp_data | output | 16 | Result bus, zero while not driven |
| rp_dv | output | 1 | High while a result is presented |
| rp_oe | output | 1 | Bus drive enable |
| cpu_data | output | 16 | Oldest result, as seen by the processor path |
| ovf | output | 1 | Sticky flag: a write was dropped because the queue was full |

## Verification
The bench holds the advance input high for several cycles to catch a design that pops on the level instead of the edge; such a design would skip results. It pulses the advance input with select low and checks that the queue does not move and the bus reads zero. A design that forgot the AND would lose a result, and a design that forgot the drive gating would put data on a bus it does not own. It fills the queue past eight entries to catch a design that overwrites the oldest entry or clears the flag. It also fires both pop paths in the same cycle, where a careless design would pop two results.

// File: rtl/rslt_port.sv
module rslt_port #(
  parameter int W = 16,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wr_data,
  input  logic         rp_adv,
  input  logic         rp_sel,
  input  logic         cpu_rd,
  output logic [W-1:0] rp_data,
  output logic         rp_dv,
  output logic         rp_oe,
  output logic [W-1:0] cpu_data,
  output logic         ovf
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] rd_ptr, wr_ptr;
  logic [CW-1:0] cnt;
  logic          adv_q;

  wire empty    = (cnt == '0);
  wire full     = (cnt == CW'(DEPTH));
  wire adv_rise = rp_adv & ~adv_q;
  wire pop      = ~empty & ((adv_rise & rp_sel) | cpu_rd);
  wire push     = wr_en & (~full | pop);
  wire [W-1:0] head = mem[rd_ptr];

  assign rp_dv    = ~empty;
  assign rp_oe    = rp_sel & rp_dv;
  assign rp_data  = rp_oe ? head : '0;
  assign cpu_data = empty ? '0 : head;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      wr_ptr <= '0;
      cnt    <= '0;
      adv_q  <= 1'b0;
      ovf    <= 1'b0;
    end else begin
      adv_q <= rp_adv;
      if (wr_en && !push) ovf <= 1'b1;
      if (push) wr_ptr <= (wr_ptr == LAST) ? '0 : wr_ptr + 1'b1;
      if (pop)  rd_ptr <= (rd_ptr == LAST) ? '0 : rd_ptr + 1'b1;
      if (push && !pop)      cnt <= cnt + 1'b1;
      else if (pop && !push) cnt <= cnt - 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= wr_data;
  end
endmodule

module rslt_port_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [W-1:0] wr_data,
  input logic         rp_adv,
  input logic         rp_sel,
  input logic         cpu_rd,
  input logic [W-1:0] rp_data,
  input logic         rp_dv,
  input logic         rp_oe,
  input logic [W-1:0] cpu_data,
  input logic         ovf
);
  assert_bus_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !rp_oe |-> (rp_data == '0));

  assert_drive_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rp_oe |-> (rp_sel && rp_dv));

  assert_no_pop_unselected_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_dv && !rp_sel && !cpu_rd) |=> (rp_dv && $stable(cpu_data)));

  assert_level_pops_once_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rp_dv && rp_adv && $past(rp_adv) && !cpu_rd) |=> (rp_dv && $stable(cpu_data)));

  assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ovf |=> ovf);

  assert_reset_clears_R7: assert property (@(posedge clk)
    !rst_n |=> (!rp_dv && !ovf));
endmodule

bind rslt_port rslt_port_chk #(.W(W)) chk_i (.*);

// File: tb/rslt_port_tb_top.sv
`timescale 1ns/1ps
module rslt_port_tb_top;
  logic        clk = 1'b0;
  logic        rst_n, wr_en, rp_adv, rp_sel, cpu_rd;
  logic [15:0] wr_data;
  logic [15:0] rp_data, cpu_data;
  logic        rp_dv, rp_oe, ovf;

  int total = 0, bad = 0;
  logic [15:0] exp_q[$];
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rslt_port dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .rp_adv(rp_adv), .rp_sel(rp_sel), .cpu_rd(cpu_rd),
    .rp_data(rp_data), .rp_dv(rp_dv), .rp_oe(rp_oe),
    .cpu_data(cpu_data), .ovf(ovf)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] expv);
    total++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, expv);
    end
  endtask

  // driver: push a result, predicting acceptance from the model depth
  task automatic push(logic [15:0] v);
    @(negedge clk);
    wr_en = 1'b1; wr_data = v;
    if (exp_q.size() < 8) exp_q.push_back(v);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  // monitor: compare presented head with scoreboard, then advance via port
  task automatic take_port(string req);
    check(req, {15'd0, rp_dv}, 16'd1);
    check(req, {15'd0, rp_oe}, {15'd0, rp_sel});
    check(req, rp_data, exp_q[0]);
    rp_adv = 1'b1;
    @(negedge clk);
    rp_adv = 1'b0;
    void'(exp_q.pop_front());
    @(negedge clk);
  endtask

  task automatic take_cpu(string req);
    check(req, cpu_data, exp_q[0]);
    cpu_rd = 1'b1;
    @(negedge clk);
    cpu_rd = 1'b0;
    void'(exp_q.pop_front());
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    exp_q.delete();
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = '0;
    rp_adv = 1'b0; rp_sel = 1'b1; cpu_rd = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R7 reset state
    check("R7 dv after reset", {15'd0, rp_dv}, 16'd0);
    check("R7 ovf after reset", {15'd0, ovf}, 16'd0);
    check("R5 bus zero when empty", rp_data, 16'd0);
    check("R8 cpu_data zero when empty", cpu_data, 16'd0);

    // R1 R2 order and valid
    push(16'hA001); push(16'hA002); push(16'hA003);
    take_port("R1 order");
    take_port("R1 order");
    take_port("R1 order");
    check("R2 dv low after last", {15'd0, rp_dv}, 16'd0);

    // R3 R5 unselected: advance ignored, bus quiet
    push(16'hB001); push(16'hB002);
    @(negedge clk);
    rp_sel = 1'b0; rp_adv = 1'b1;
    @(negedge clk);
    rp_adv = 1'b0;
    @(negedge clk);
    check("R3 no pop unselected", cpu_data, 16'hB001);
    check("R5 oe low unselected", {15'd0, rp_oe}, 16'd0);
    check("R5 bus zero unselected", rp_data, 16'd0);
    check("R2 dv still high", {15'd0, rp_dv}, 16'd1);
    // R8 processor path pops while port idle
    take_cpu("R8 cpu pop");
    check("R8 next head", cpu_data, 16'hB002);
    take_cpu("R8 cpu pop");
    check("R2 dv low after cpu drain", {15'd0, rp_dv}, 16'd0);
    rp_sel = 1'b1;

    // R4 held advance pops once
    push(16'hC001); push(16'hC002); push(16'hC003);
    rp_adv = 1'b1;
    repeat (4) @(negedge clk);
    rp_adv = 1'b0;
    void'(exp_q.pop_front());
    @(negedge clk);
    check("R4 held level one pop", rp_data, 16'hC002);

    // R9 both paths in one cycle
    rp_adv = 1'b1; cpu_rd = 1'b1;
    @(negedge clk);
    rp_adv = 1'b0; cpu_rd = 1'b0;
    void'(exp_q.pop_front());
    @(negedge clk);
    check("R9 single pop", rp_data, 16'hC003);
    take_port("R9 remaining");
    check("R2 empty", {15'd0, rp_dv}, 16'd0);

    // R6 overflow
    for (int i = 0; i < 9; i++) push(16'hD000 + 16'(i));
    check("R6 ovf set", {15'd0, ovf}, 16'd1);
    for (int i = 0; i < 8; i++) take_port("R6 kept entries");
    check("R6 ninth dropped", {15'd0, rp_dv}, 16'd0);
    push(16'hE001);
    check("R6 ovf sticky", {15'd0, ovf}, 16'd1);

    // R7 reset mid-queue
    push(16'hE002);
    do_reset();
    check("R7 queue cleared", {15'd0, rp_dv}, 16'd0);
    check("R7 ovf cleared", {15'd0, ovf}, 16'd0);
    push(16'hF001);
    take_port("R7 after reset");

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule